// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block sends audio words one bit per bit clock on a single serial data line and produces a frame sync pulse that marks where each frame begins. A frame holds one or two words. Each word can be 8 to 32 bits long. The sync pulse can be set anywhere from one bit clock wide up to the length of the first word. It can also be moved one bit clock earlier, so that it leads the first data bit. Words can go out most-significant bit first or least-significant bit first.

Words come from a show-ahead transmit FIFO interface. The data is valid whenever the FIFO is not empty, and it is consumed by a one-cycle read strobe. The block raises that strobe in the last bit clock of the word before, so the fetched word starts shifting on the next bit clock. If the FIFO is empty at one of these fetch points, the block records an underrun: it sets a sticky error flag and stops reading. The serial line is held low while this lasts, but the frame sync keeps its timing. After software pulses the clear input, transmission restarts in one of two ways. The first resumes at the next frame boundary. The second resumes at the next occurrence of the word slot whose fetch failed.

The system clock is the bit clock, with one bit transferred per clock. Configuration inputs are expected to stay constant while reset is released.

Top module: `serial_frame_tx`

## Requirements
- R1: While `rst` is high, `tx_data`, `err_flag` and `fifo_rd` are all 0.
- R2: A frame lasts (`cfg_bits_m1`+1)×(`cfg_slots_m1`+1) bit clocks, and `cfg_slots_m1` is 0 for one word or 1 for two. The first bit clock after reset is released carries bit 0 of word 0 of a frame. Frames then follow one another with no gap.
- R3: With `cfg_sync_early`=0, `tx_sync` is high in bit clocks 0 to `cfg_sync_m1` of each frame and low otherwise. `cfg_sync_m1` must not exceed `cfg_bits_m1`.
- R4: With `cfg_sync_early`=1, `tx_sync` is high in the last bit clock of the previous frame and in bit clocks 0 to `cfg_sync_m1`−1 of the frame. The pulse therefore keeps its width of `cfg_sync_m1`+1 but begins one bit clock sooner.
- R5: Words sit at the low end of `fifo_data`. With `cfg_msb_first`=1, bit `cfg_bits_m1` goes out first and bit 0 last. With `cfg_msb_first`=0, the order is reversed.
- R6: While running, `fifo_rd` is high for exactly one bit clock per word, namely the last bit clock of the preceding word, and only if `fifo_empty` is 0 then. The word present on `fifo_data` in that cycle is the one sent next.
- R7: If `fifo_empty` is 1 at a fetch point while running, no read is issued, `err_flag` is 1 from the next bit clock, and the word that would have been sent is sent as all zeros.
- R8: After an underrun and until recovery, `fifo_rd` stays 0 and `tx_data` stays 0, while `tx_sync` keeps its frame timing.
- R9: `err_flag` stays set until a cycle with `err_clr`=1 clears it. If an underrun and `err_clr` occur in the same cycle, the flag is set.
- R10: With `cfg_recover`=0, once the flag is clear, reading resumes at the fetch point of word 0 of the next frame.
- R11: With `cfg_recover`=1, once the flag is clear, reading resumes at the next fetch point for the same word slot whose fetch failed.
- R12: Word lengths from 8 to 32 bits (`cfg_bits_m1` 7 to 31) are all supported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_slots_m1 | input | SW | Words per frame minus one |
| cfg_bits_m1 | input | BW | Bits per word minus one |
| cfg_sync_m1 | input | BW | Sync pulse width in bit clocks minus one |
| cfg_sync_early | input | 1 | Move sync one bit clock ahead of the frame |
| cfg_msb_first | input | 1 | 1: MSB first, 0: LSB first |
| cfg_recover | input | 1 | 0: resume at next frame, 1: resume at failed slot |
| fifo_empty | input | 1 | Transmit FIFO holds no word |
| fifo_data | input | WORD_MAX | Head word of the FIFO (show-ahead) |
| fifo_rd | output | 1 | Pop strobe for the FIFO head word |
| err_clr | input | 1 | Single-cycle clear of the underrun flag |
| err_flag | output | 1 | Sticky underrun flag |
| tx_data | output | 1 | Serial data line |
| tx_sync | output | 1 | Frame sync line |

## Verification
The bench builds the block with its default parameters: up to 32-bit words and up to two words per frame. With these defaults, a single netlist covers every supported word length, both frame sizes, and sync widths up to a full 32-bit word. A configuration table covers short and long words, both bit orders, both sync positions, and sync widths from one bit up to the whole first word. Directed runs starve the FIFO in the second word slot. This lets the two recovery modes resume at different bit clocks, so the point where each one restarts can be told apart exactly.

// File: rtl/sft_pkg.sv
package sft_pkg;

    // Restart policy after a FIFO underrun has been cleared
    typedef enum logic {
        REC_NEXT_FRAME = 1'b0,
        REC_SAME_SLOT  = 1'b1
    } recover_e;

    // Timing marks produced by the position counters
    typedef struct packed {
        logic word_end;   // last bit clock of the current word
        logic frame_end;  // last bit clock of the current frame
    } tick_t;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sft_bit_timer.sv
module sft_bit_timer
    import sft_pkg::*;
#(
    parameter int unsigned BW = 5,
    parameter int unsigned SW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] bits_m1,
    input  logic [SW-1:0] slots_m1,
    output logic [BW-1:0] bit_idx,
    output logic [SW-1:0] slot_idx,
    output logic [SW-1:0] next_slot,
    output tick_t         tick
);

    always_comb begin
        tick.word_end  = (bit_idx == bits_m1);
        tick.frame_end = tick.word_end && (slot_idx == slots_m1);
        next_slot      = (slot_idx == slots_m1) ? '0 : slot_idx + 1'b1;
    end

    // Reset parks the counters on the final bit of a frame, so the first
    // fetch happens right away and bit 0 of word 0 follows.
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_idx  <= bits_m1;
            slot_idx <= slots_m1;
        end else if (tick.word_end) begin
            bit_idx  <= '0;
            slot_idx <= next_slot;
        end else begin
            bit_idx  <= bit_idx + 1'b1;
        end
    end

    a_r2_word_wrap: assert property (@(posedge clk) disable iff (rst)
        tick.word_end |=> (bit_idx == '0));

    a_r2_slot_bound: assert property (@(posedge clk) disable iff (rst)
        slot_idx <= slots_m1);

endmodule

// File: rtl/sft_sync_gen.sv
module sft_sync_gen
    import sft_pkg::*;
#(
    parameter int unsigned BW = 5,
    parameter int unsigned SW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  tick_t         tick,
    input  logic [BW-1:0] bit_idx,
    input  logic [SW-1:0] slot_idx,
    input  logic [BW-1:0] bits_m1,
    input  logic [BW-1:0] sync_m1,
    input  logic          early,
    output logic          sync
);

    logic first_slot;
    logic win_on_time;
    logic win_early;

    always_comb begin
        first_slot  = (slot_idx == '0);
        win_on_time = first_slot && (bit_idx <= sync_m1);
        win_early   = tick.frame_end || (first_slot && (bit_idx < sync_m1));
        sync        = early ? win_early : win_on_time;
    end

    a_r3_sync_fits: assert property (@(posedge clk) disable iff (rst)
        sync_m1 <= bits_m1);

    a_r3_frame_open: assert property (@(posedge clk) disable iff (rst)
        (!early && tick.frame_end) |=> sync);

endmodule

// File: rtl/sft_underrun_ctl.sv
module sft_underrun_ctl
    import sft_pkg::*;
#(
    parameter int unsigned SW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          word_end,
    input  logic [SW-1:0] next_slot,
    input  logic          fifo_empty,
    input  logic          err_clr,
    input  logic          recover,
    output logic          fifo_rd,
    output logic          err_flag
);

    recover_e      mode;
    logic          muted;
    logic [SW-1:0] miss_slot;
    logic [SW-1:0] resume_slot;
    logic          may_run;
    logic          miss;

    always_comb begin
        mode        = recover_e'(recover);
        resume_slot = (mode == REC_SAME_SLOT) ? miss_slot : '0;
        may_run     = !muted || (!err_flag && (next_slot == resume_slot));
        fifo_rd     = !rst && word_end && may_run && !fifo_empty;
        miss        = !rst && word_end && may_run && fifo_empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag  <= 1'b0;
            muted     <= 1'b0;
            miss_slot <= '0;
        end else begin
            if (miss)          err_flag <= 1'b1;   // a new underrun wins over clear
            else if (err_clr)  err_flag <= 1'b0;
            if (word_end)      muted    <= !fifo_rd;
            if (miss)          miss_slot <= next_slot;
        end
    end

    a_r8_no_read_flagged: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> !fifo_rd);

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clr) |=> err_flag);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        (word_end && fifo_empty && !muted) |=> err_flag);

    a_r6_read_has_data: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> (word_end && !fifo_empty));

endmodule

// File: rtl/sft_shifter.sv
module sft_shifter #(
    parameter int unsigned WM = 32,
    parameter int unsigned BW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          word_end,
    input  logic          take,
    input  logic [WM-1:0] din,
    input  logic [BW-1:0] bit_idx,
    input  logic [BW-1:0] bits_m1,
    input  logic          msb_first,
    output logic          dout
);

    logic [WM-1:0] hold;
    logic [BW-1:0] sel;

    always_comb begin
        sel  = msb_first ? (bits_m1 - bit_idx) : bit_idx;
        dout = hold[sel];
    end

    // A missed or muted fetch loads zeros, keeping the line low for that word
    always_ff @(posedge clk) begin
        if (rst)           hold <= '0;
        else if (word_end) hold <= take ? din : '0;
    end

    a_r7_quiet_word: assert property (@(posedge clk) disable iff (rst)
        (word_end && !take) |=> !dout);

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sft_pkg::*;
#(
    parameter  int unsigned WORD_MAX    = 32,
    parameter  int unsigned FRAME_WORDS = 2,
    localparam int unsigned BW          = idx_width(WORD_MAX),
    localparam int unsigned SW          = idx_width(FRAME_WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SW-1:0]       cfg_slots_m1,
    input  logic [BW-1:0]       cfg_bits_m1,
    input  logic [BW-1:0]       cfg_sync_m1,
    input  logic                cfg_sync_early,
    input  logic                cfg_msb_first,
    input  logic                cfg_recover,
    input  logic                fifo_empty,
    input  logic [WORD_MAX-1:0] fifo_data,
    output logic                fifo_rd,
    input  logic                err_clr,
    output logic                err_flag,
    output logic                tx_data,
    output logic                tx_sync
);

    logic [BW-1:0] bit_idx;
    logic [SW-1:0] slot_idx;
    logic [SW-1:0] next_slot;
    tick_t         tick;

    sft_bit_timer #(.BW(BW), .SW(SW)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .bits_m1   (cfg_bits_m1),
        .slots_m1  (cfg_slots_m1),
        .bit_idx   (bit_idx),
        .slot_idx  (slot_idx),
        .next_slot (next_slot),
        .tick      (tick)
    );

    sft_sync_gen #(.BW(BW), .SW(SW)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .bit_idx  (bit_idx),
        .slot_idx (slot_idx),
        .bits_m1  (cfg_bits_m1),
        .sync_m1  (cfg_sync_m1),
        .early    (cfg_sync_early),
        .sync     (tx_sync)
    );

    sft_underrun_ctl #(.SW(SW)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .word_end   (tick.word_end),
        .next_slot  (next_slot),
        .fifo_empty (fifo_empty),
        .err_clr    (err_clr),
        .recover    (cfg_recover),
        .fifo_rd    (fifo_rd),
        .err_flag   (err_flag)
    );

    sft_shifter #(.WM(WORD_MAX), .BW(BW)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .word_end  (tick.word_end),
        .take      (fifo_rd),
        .din       (fifo_data),
        .bit_idx   (bit_idx),
        .bits_m1   (cfg_bits_m1),
        .msb_first (cfg_msb_first),
        .dout      (tx_data)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |-> (!fifo_rd));

endmodule

// File: tb/serial_frame_tx_bench.sv
`timescale 1ns/1ps
module serial_frame_tx_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [0:0]  cfg_slots_m1 = '0;
    logic [4:0]  cfg_bits_m1 = 5'd7;
    logic [4:0]  cfg_sync_m1 = '0;
    logic        cfg_sync_early = 1'b0;
    logic        cfg_msb_first = 1'b1;
    logic        cfg_recover = 1'b0;
    logic        fifo_empty = 1'b0;
    logic [31:0] fifo_data;
    logic        fifo_rd;
    logic        err_clr = 1'b0;
    logic        err_flag;
    logic        tx_data;
    logic        tx_sync;

    int checks = 0;
    int fails  = 0;
    int k;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    serial_frame_tx u_serial_frame_tx (
        .clk(clk), .rst(rst), .cfg_slots_m1(cfg_slots_m1), .cfg_bits_m1(cfg_bits_m1),
        .cfg_sync_m1(cfg_sync_m1), .cfg_sync_early(cfg_sync_early),
        .cfg_msb_first(cfg_msb_first), .cfg_recover(cfg_recover),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
        .err_clr(err_clr), .err_flag(err_flag), .tx_data(tx_data), .tx_sync(tx_sync)
    );

    function automatic logic [31:0] gen(input int n);
        return ((32'(n) + 32'd1) * 32'h9E3779B1) ^ 32'h5A0FC3E1;
    endfunction

    // Show-ahead FIFO model: word n is the n-th one popped since reset
    assign fifo_data = gen(k);
    always @(posedge clk) begin
        if (rst)          k <= 0;
        else if (fifo_rd) k <= k + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(input int sl, input int bm, input int sm,
                            input bit ea, input bit ms, input bit rc);
        @(negedge clk);
        rst = 1'b1; fifo_empty = 1'b0; err_clr = 1'b0;
        cfg_slots_m1 = 1'(sl); cfg_bits_m1 = 5'(bm); cfg_sync_m1 = 5'(sm);
        cfg_sync_early = ea; cfg_msb_first = ms; cfg_recover = rc;
        repeat (3) @(negedge clk);
        chk(tx_data == 1'b0, "R1 tx_data", int'(tx_data), 0);
        chk(err_flag == 1'b0, "R1 err_flag", int'(err_flag), 0);
        chk(fifo_rd == 1'b0, "R1 fifo_rd", int'(fifo_rd), 0);
        rst = 1'b0;
    endtask

    // Configuration table: slots_m1, bits_m1, sync_m1, early, msb_first.
    // Word lengths 8, 12, 16, 24 and 32 cover R12.
    localparam int NV = 5;
    localparam int V_SL [NV] = '{1, 1, 0, 0, 1};
    localparam int V_BM [NV] = '{7, 15, 31, 11, 23};
    localparam int V_SM [NV] = '{0, 3, 31, 5, 23};
    localparam bit V_EA [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam bit V_MS [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

    task automatic run_vec(input int v);
        int w, fl, n, j, p, eb;
        bit es, er;
        w  = V_BM[v] + 1;
        fl = w * (V_SL[v] + 1);
        do_reset(V_SL[v], V_BM[v], V_SM[v], V_EA[v], V_MS[v], 1'b0);
        for (int i = 0; i < 2 * fl; i++) begin
            @(negedge clk);
            n  = i / w;
            j  = i % w;
            p  = i % fl;
            eb = int'(V_MS[v] ? gen(n)[w-1-j] : gen(n)[j]);
            chk(int'(tx_data) == eb, "R5 R12 tx_data bit", int'(tx_data), eb);
            if (V_EA[v]) begin
                es = (p == fl - 1) || (p < V_SM[v]);
                chk(tx_sync == es, "R4 R2 early sync", int'(tx_sync), int'(es));
            end else begin
                es = (p <= V_SM[v]);
                chk(tx_sync == es, "R3 R2 sync window", int'(tx_sync), int'(es));
            end
            er = (j == w - 1);
            chk(fifo_rd == er, "R6 fetch point", int'(fifo_rd), int'(er));
        end
    endtask

    // 8-bit words, 2 per frame; starve the fetch for slot 1 of frame 1
    task automatic run_miss(input bit mode);
        int eb;
        do_reset(1, 7, 0, 1'b0, 1'b1, mode);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (i == 23) begin
                chk(fifo_rd == 1'b0, "R7 no read on empty", int'(fifo_rd), 0);
                chk(err_flag == 1'b0, "R7 flag before miss", int'(err_flag), 0);
            end
            if (i == 24) chk(err_flag == 1'b1, "R7 flag set", int'(err_flag), 1);
            if (i >= 24 && i < 40) chk(tx_data == 1'b0, "R8 line low", int'(tx_data), 0);
            if (i == 31 || i == 39) chk(fifo_rd == 1'b0, "R8 no read while flagged", int'(fifo_rd), 0);
            if (i == 32 || i == 48) chk(tx_sync == 1'b1, "R8 sync keeps running", int'(tx_sync), 1);
            if (i == 39) chk(err_flag == 1'b1, "R9 flag sticky", int'(err_flag), 1);
            if (i == 41) chk(err_flag == 1'b0, "R9 flag cleared", int'(err_flag), 0);
            if (!mode) begin
                if (i == 47) chk(fifo_rd == 1'b1, "R10 resume read", int'(fifo_rd), 1);
                if (i >= 40 && i < 48) chk(tx_data == 1'b0, "R10 low before resume", int'(tx_data), 0);
                if (i >= 48 && i < 56) begin
                    eb = int'(gen(3)[7 - (i - 48)]);
                    chk(int'(tx_data) == eb, "R10 resumed word", int'(tx_data), eb);
                end
            end else begin
                if (i == 47) chk(fifo_rd == 1'b0, "R11 skip slot 0", int'(fifo_rd), 0);
                if (i >= 40 && i < 56) chk(tx_data == 1'b0, "R11 low before resume", int'(tx_data), 0);
                if (i == 55) chk(fifo_rd == 1'b1, "R11 resume read", int'(fifo_rd), 1);
                if (i >= 56 && i < 64) begin
                    eb = int'(gen(3)[7 - (i - 56)]);
                    chk(int'(tx_data) == eb, "R11 resumed word", int'(tx_data), eb);
                end
            end
            if (i == 22) fifo_empty = 1'b1;
            if (i == 24) fifo_empty = 1'b0;
            if (i == 40) err_clr = 1'b1;
            if (i == 41) err_clr = 1'b0;
        end
    endtask

    task automatic run_priority();
        do_reset(1, 7, 0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i == 7) chk(fifo_rd == 1'b0, "R9 no read on empty", int'(fifo_rd), 0);
            if (i == 8) chk(err_flag == 1'b1, "R9 set beats clear", int'(err_flag), 1);
            if (i == 5) err_clr = 1'b1;
            if (i == 6) fifo_empty = 1'b1;
            if (i == 8) begin err_clr = 1'b0; fifo_empty = 1'b0; end
        end
    endtask

    initial begin
        for (int v = 0; v < NV; v++) run_vec(v);
        run_miss(1'b0);
        run_miss(1'b1);
        run_priority();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule